// File: doc/BRIEF.md
# Stop-Clock Power State Controller

This block sequences a processor core into and out of a low-power stopped state on an active-low stop request. When the request is recognized, the controller lets the instruction pipeline drain and outstanding bus traffic finish. It then raises an acknowledge special-cycle request. The core clock enable is gated only after the bus has returned ready for that cycle and, after that, the write buffer has reported empty.

While stopped, a free-running timestamp counter keeps counting and the interrupt-class inputs stay sampled, while cache-flush requests are refused. A snoop moves the controller into an inquire sub-state. When the snoop completes, the controller returns to the stopped state without a second acknowledge cycle. Dropping the request starts an exit of fixed, parameterised latency back to normal execution. If the request comes back during that exit, at least one instruction must retire before a new entry begins.

Top module: `stop_clock_ctl`

## Requirements
- R1: While reset is sampled high, and on the first clock after it, the state code is 0 (Normal), the timestamp is 0, the acknowledge request is low and the core clock enable is high.
- R2: A low stop request sampled in Normal moves to state code 1 (Drain). The controller leaves Drain only on a clock where pipeEmpty and busIdle are both high, and it moves to state code 2 (Acknowledge).
- R3: ackCycleReq is high exactly while in Acknowledge. It stays high until busReadyN is sampled low, which moves the controller to state code 3 (Write-buffer wait).
- R4: State code 4 (Stopped) is entered from Write-buffer wait only on a clock where wbEmptyN is sampled low. coreClkEn is low in Stopped and in Inquire.
- R5: The timestamp counter increments by exactly one on every clock outside reset, in every state.
- R6: snoopReq sampled high in Stopped gives state code 5 (Inquire) with snoopAck high. snoopDone sampled high there returns to Stopped, and ackCycleReq stays low throughout.
- R7: flushAccept follows flushReq in every state except Stopped and Inquire, where it is held low. irqSampleEn is high in every state after the first clock out of reset.
- R8: A high (negated) stop request sampled in Stopped gives state code 6 (Exiting). Normal is reached exactly EXIT_LAT clocks after that sample, and always in fewer than 10.
- R9: If the stop request is low during any Exiting clock, Normal does not start a new entry until instrRetired has been sampled high in Normal. Without such a reassertion, a later request is taken at once.
- R10: While in Stopped with the request held low and no snoop, the state code, ackCycleReq and coreClkEn do not change.
- R11: Reset sampled high takes priority in any state. It returns the controller to Normal, clears the timestamp and drops the acknowledge request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| stopReqN | input | 1 | Active-low stop-clock request |
| pipeEmpty | input | 1 | Instruction pipeline has drained |
| busIdle | input | 1 | No pending or in-progress bus cycles |
| busReadyN | input | 1 | Active-low bus ready for the acknowledge cycle |
| wbEmptyN | input | 1 | Active-low write buffer empty |
| snoopReq | input | 1 | Snoop cycle request |
| snoopDone | input | 1 | Snoop cycle finished |
| instrRetired | input | 1 | An instruction retired this clock |
| flushReq | input | 1 | Cache-flush request |
| coreClkEn | output | 1 | Core clock enable |
| ackCycleReq | output | 1 | Acknowledge special-cycle request |
| snoopAck | output | 1 | Snoop being serviced while stopped |
| flushAccept | output | 1 | Flush request accepted |
| irqSampleEn | output | 1 | Interrupt, init, NMI, SMI and reset sampling enabled |
| tscValue | output | TSC_W | Timestamp counter |
| stateCode | output | 3 | Current state code |

## Verification
On every cycle, the checker confirms the timestamp step, that Stopped is entered only through the write-buffer handshake, that Drain is left only with both drain conditions met, that no acknowledge appears on the return from a snoop, that flushes are refused while stopped, that the exit bound is kept and that reset wins. Only the bench scenarios can show the cycle-exact latencies of the handshakes, the hold of the outputs through a long stop, and the retire-before-re-entry ordering after a request that is reasserted during exit. The bench shows these by sweeping the drain, bus-ready and write-buffer delays and replaying the exit and snoop paths for each combination.

// File: rtl/stop_clock_pkg.sv
package stop_clock_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL  = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_ACK     = 3'd2,
    ST_WBWAIT  = 3'd3,
    ST_STOPPED = 3'd4,
    ST_INQUIRE = 3'd5,
    ST_EXITING = 3'd6
  } stopState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic exitStart;    // negated request sampled while stopped
    logic retireArm;    // request seen low during exit
    logic retireClear;  // instruction retired in Normal
  } ctrlStrobes_t;

endpackage

// File: rtl/stop_clock_dp.sv
module stop_clock_dp
  import stop_clock_pkg::*;
#(
  parameter int TSC_W    = 64,
  parameter int EXIT_LAT = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strobes,
  output logic [TSC_W-1:0] tscValue,
  output logic             exitDone,
  output logic             mustRetire,
  output logic             irqSampleEn
);

  localparam int CNT_W = (EXIT_LAT < 2) ? 1 : $clog2(EXIT_LAT + 1);
  localparam logic [CNT_W-1:0] EXIT_LOAD = CNT_W'(EXIT_LAT - 1);

  logic [CNT_W-1:0] exitCnt;

  // free-running timestamp
  always_ff @(posedge clk) begin
    if (rst) tscValue <= '0;
    else     tscValue <= tscValue + 1'b1;
  end

  // exit latency counter
  always_ff @(posedge clk) begin
    if (rst)                    exitCnt <= '0;
    else if (strobes.exitStart) exitCnt <= EXIT_LOAD;
    else if (exitCnt != '0)     exitCnt <= exitCnt - 1'b1;
  end

  assign exitDone = (exitCnt == '0);

  // re-entry guard
  always_ff @(posedge clk) begin
    if (rst)                      mustRetire <= 1'b0;
    else if (strobes.retireArm)   mustRetire <= 1'b1;
    else if (strobes.retireClear) mustRetire <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irqSampleEn <= 1'b0;
    else     irqSampleEn <= 1'b1;
  end

endmodule

// File: rtl/stop_clock_fsm.sv
module stop_clock_fsm
  import stop_clock_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         stopReqN,
  input  logic         pipeEmpty,
  input  logic         busIdle,
  input  logic         busReadyN,
  input  logic         wbEmptyN,
  input  logic         snoopReq,
  input  logic         snoopDone,
  input  logic         instrRetired,
  input  logic         flushReq,
  input  logic         exitDone,
  input  logic         mustRetire,
  output ctrlStrobes_t strobes,
  output logic         coreClkEn,
  output logic         ackCycleReq,
  output logic         snoopAck,
  output logic         flushAccept,
  output logic [2:0]   stateCode
);

  stopState_t state, stateNext;
  logic       stoppedFamily;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_NORMAL:  if (!stopReqN && !mustRetire)  stateNext = ST_DRAIN;
      ST_DRAIN:   if (pipeEmpty && busIdle)      stateNext = ST_ACK;
      ST_ACK:     if (!busReadyN)                stateNext = ST_WBWAIT;
      ST_WBWAIT:  if (!wbEmptyN)                 stateNext = ST_STOPPED;
      ST_STOPPED: begin
        if (stopReqN)      stateNext = ST_EXITING;
        else if (snoopReq) stateNext = ST_INQUIRE;
      end
      ST_INQUIRE: if (snoopDone)                 stateNext = ST_STOPPED;
      ST_EXITING: if (exitDone)                  stateNext = ST_NORMAL;
      default:                                   stateNext = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_NORMAL;
    else     state <= stateNext;
  end

  always_comb begin
    strobes             = '0;
    strobes.exitStart   = (state == ST_STOPPED) && stopReqN;
    strobes.retireArm   = (state == ST_EXITING) && !stopReqN;
    strobes.retireClear = (state == ST_NORMAL) && instrRetired;
  end

  assign stoppedFamily = (state == ST_STOPPED) || (state == ST_INQUIRE);
  assign coreClkEn     = !stoppedFamily;
  assign ackCycleReq   = (state == ST_ACK);
  assign snoopAck      = (state == ST_INQUIRE);
  assign flushAccept   = flushReq && !stoppedFamily;
  assign stateCode     = state;

endmodule

// File: rtl/stop_clock_ctl.sv
module stop_clock_ctl
  import stop_clock_pkg::*;
#(
  parameter int TSC_W    = 64,
  parameter int EXIT_LAT = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stopReqN,
  input  logic             pipeEmpty,
  input  logic             busIdle,
  input  logic             busReadyN,
  input  logic             wbEmptyN,
  input  logic             snoopReq,
  input  logic             snoopDone,
  input  logic             instrRetired,
  input  logic             flushReq,
  output logic             coreClkEn,
  output logic             ackCycleReq,
  output logic             snoopAck,
  output logic             flushAccept,
  output logic             irqSampleEn,
  output logic [TSC_W-1:0] tscValue,
  output logic [2:0]       stateCode
);

  ctrlStrobes_t strobes;
  logic         exitDone;
  logic         mustRetire;

  stop_clock_fsm u_fsm (
    .clk(clk), .rst(rst), .stopReqN(stopReqN), .pipeEmpty(pipeEmpty),
    .busIdle(busIdle), .busReadyN(busReadyN), .wbEmptyN(wbEmptyN),
    .snoopReq(snoopReq), .snoopDone(snoopDone), .instrRetired(instrRetired),
    .flushReq(flushReq), .exitDone(exitDone), .mustRetire(mustRetire),
    .strobes(strobes), .coreClkEn(coreClkEn), .ackCycleReq(ackCycleReq),
    .snoopAck(snoopAck), .flushAccept(flushAccept), .stateCode(stateCode)
  );

  stop_clock_dp #(.TSC_W(TSC_W), .EXIT_LAT(EXIT_LAT)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .tscValue(tscValue),
    .exitDone(exitDone), .mustRetire(mustRetire), .irqSampleEn(irqSampleEn)
  );

endmodule

// File: rtl/stop_clock_ctl_chk.sv
module stop_clock_ctl_chk #(
  parameter int TSC_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             pipeEmpty,
  input logic             busIdle,
  input logic             wbEmptyN,
  input logic             ackCycleReq,
  input logic             flushAccept,
  input logic [TSC_W-1:0] tscValue,
  input logic [2:0]       stateCode
);

  logic [7:0] exitRun;

  always_ff @(posedge clk) begin
    if (rst)                                   exitRun <= '0;
    else if (stateCode == 3'd6 && exitRun != 8'hFF) exitRun <= exitRun + 1'b1;
    else if (stateCode != 3'd6)                exitRun <= '0;
  end

  p_tsc_step_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> tscValue == $past(tscValue) + 1'b1);

  p_drain_exit_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stateCode) == 3'd1 && stateCode == 3'd2)
      |-> $past(pipeEmpty && busIdle));

  p_stop_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && stateCode == 3'd4 && $past(stateCode) != 3'd4 && $past(stateCode) != 3'd5)
      |-> ($past(stateCode) == 3'd3 && !$past(wbEmptyN)));

  p_no_second_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stateCode) == 3'd5) |-> !ackCycleReq);

  p_flush_refused_r7: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 3'd4 || stateCode == 3'd5) |-> !flushAccept);

  p_exit_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 3'd6) |-> exitRun < 8'd9);

  p_reset_wins_r11: assert property (@(posedge clk)
    $past(rst) |-> (stateCode == 3'd0 && tscValue == '0 && !ackCycleReq));

endmodule

bind stop_clock_ctl stop_clock_ctl_chk #(.TSC_W(TSC_W)) u_chk (
  .clk(clk), .rst(rst), .pipeEmpty(pipeEmpty), .busIdle(busIdle),
  .wbEmptyN(wbEmptyN), .ackCycleReq(ackCycleReq), .flushAccept(flushAccept),
  .tscValue(tscValue), .stateCode(stateCode)
);

// File: tb/tb_stop_clock_ctl.sv
module tb_stop_clock_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int EXIT_LAT   = 6;
  localparam int TSC_W      = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stopReqN = 1'b1, pipeEmpty = 1'b0, busIdle = 1'b0, busReadyN = 1'b1;
  logic wbEmptyN = 1'b1, snoopReq = 1'b0, snoopDone = 1'b0;
  logic instrRetired = 1'b0, flushReq = 1'b0;
  logic coreClkEn, ackCycleReq, snoopAck, flushAccept, irqSampleEn;
  logic [TSC_W-1:0] tscValue;
  logic [2:0] stateCode;

  int nChecks = 0;
  int nFails  = 0;
  longint expTsc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stop_clock_ctl #(.TSC_W(TSC_W), .EXIT_LAT(EXIT_LAT)) dut (
    .clk(clk), .rst(rst), .stopReqN(stopReqN), .pipeEmpty(pipeEmpty),
    .busIdle(busIdle), .busReadyN(busReadyN), .wbEmptyN(wbEmptyN),
    .snoopReq(snoopReq), .snoopDone(snoopDone), .instrRetired(instrRetired),
    .flushReq(flushReq), .coreClkEn(coreClkEn), .ackCycleReq(ackCycleReq),
    .snoopAck(snoopAck), .flushAccept(flushAccept), .irqSampleEn(irqSampleEn),
    .tscValue(tscValue), .stateCode(stateCode)
  );

  task automatic tick();
    @(posedge clk);
    if (rst) expTsc = 0; else expTsc = expTsc + 1;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enterStop(input int dDrain, input int dBrdy, input int dEwbe);
    stopReqN = 1'b0;
    tick();
    chk("R2 drain entered", stateCode, 1);
    chk("R3 no ack in drain", ackCycleReq, 0);
    for (int i = 0; i < dDrain; i++) begin
      tick();
      chk("R2 drain holds", stateCode, 1);
    end
    pipeEmpty = 1'b1;
    tick();
    chk("R2 pipe only, still drain", stateCode, 1);
    busIdle = 1'b1;
    tick();
    chk("R2 ack state", stateCode, 2);
    chk("R3 ack raised", ackCycleReq, 1);
    chk("R4 clock on in ack", coreClkEn, 1);
    pipeEmpty = 1'b0; busIdle = 1'b0;
    for (int i = 0; i < dBrdy; i++) begin
      tick();
      chk("R3 ack held", ackCycleReq, 1);
    end
    busReadyN = 1'b0;
    tick();
    busReadyN = 1'b1;
    chk("R3 write-buffer wait", stateCode, 3);
    chk("R3 ack dropped", ackCycleReq, 0);
    for (int i = 0; i < dEwbe; i++) begin
      tick();
      chk("R4 waits for wb empty", stateCode, 3);
    end
    wbEmptyN = 1'b0;
    tick();
    wbEmptyN = 1'b1;
    chk("R4 stopped", stateCode, 4);
    chk("R4 clock gated", coreClkEn, 0);
  endtask

  task automatic exitStop(input bit reassert);
    stopReqN = 1'b1;
    tick();
    chk("R8 exiting", stateCode, 6);
    for (int k = 1; k < EXIT_LAT; k++) begin
      if (reassert && k == 2) stopReqN = 1'b0;
      tick();
      chk("R8 still exiting", stateCode, 6);
    end
    tick();
    chk("R8 normal at latency", stateCode, 0);
    chk("R8 clock restored", coreClkEn, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    chk("R1 reset state", stateCode, 0);
    chk("R1 reset tsc", tscValue, 0);
    chk("R1 reset ack", ackCycleReq, 0);
    chk("R1 reset clk en", coreClkEn, 1);
    rst = 1'b0;
    tick();
    chk("R7 irq sampling on", irqSampleEn, 1);
    flushReq = 1'b1;
    #1 chk("R7 flush accepted in normal", flushAccept, 1);
    flushReq = 1'b0;

    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++) begin
          enterStop(a, b, c);
          chk("R5 tsc counts", tscValue, expTsc);
          // hold while stopped
          for (int h = 0; h < 3; h++) begin
            tick();
            chk("R10 state held", stateCode, 4);
            chk("R10 ack held low", ackCycleReq, 0);
            chk("R10 clock held off", coreClkEn, 0);
          end
          flushReq = 1'b1;
          #1 chk("R7 flush ignored stopped", flushAccept, 0);
          chk("R7 irq sampling stopped", irqSampleEn, 1);
          flushReq = 1'b0;
          // snoop
          snoopReq = 1'b1;
          tick();
          snoopReq = 1'b0;
          chk("R6 inquire", stateCode, 5);
          chk("R6 snoop ack", snoopAck, 1);
          chk("R4 clock off in inquire", coreClkEn, 0);
          for (int s = 0; s < a; s++) begin
            tick();
            chk("R6 inquire holds", stateCode, 5);
          end
          flushReq = 1'b1;
          #1 chk("R7 flush ignored inquire", flushAccept, 0);
          flushReq = 1'b0;
          snoopDone = 1'b1;
          tick();
          snoopDone = 1'b0;
          chk("R6 back to stopped", stateCode, 4);
          chk("R6 no second ack", ackCycleReq, 0);
          tick();
          chk("R6 stays stopped", stateCode, 4);
          exitStop(1'b0);
          chk("R5 tsc after exit", tscValue, expTsc);
        end

    // R9: no reassertion -> immediate re-entry
    stopReqN = 1'b0;
    tick();
    chk("R9 immediate re-entry", stateCode, 1);
    stopReqN = 1'b1;
    pipeEmpty = 1'b1; busIdle = 1'b1;
    tick();
    pipeEmpty = 1'b0; busIdle = 1'b0;
    stopReqN = 1'b0;
    busReadyN = 1'b0; tick(); busReadyN = 1'b1;
    wbEmptyN = 1'b0; tick(); wbEmptyN = 1'b1;
    chk("R4 stopped again", stateCode, 4);

    // R9: reassert during exit
    exitStop(1'b1);
    for (int w = 0; w < 4; w++) begin
      tick();
      chk("R9 waits for retire", stateCode, 0);
    end
    instrRetired = 1'b1;
    tick();
    instrRetired = 1'b0;
    chk("R9 retire sampled", stateCode, 0);
    tick();
    chk("R9 entry after retire", stateCode, 1);

    // R11: reset from acknowledge
    pipeEmpty = 1'b1; busIdle = 1'b1;
    tick();
    pipeEmpty = 1'b0; busIdle = 1'b0;
    chk("R11 in ack before reset", ackCycleReq, 1);
    rst = 1'b1;
    tick();
    chk("R11 reset from ack", stateCode, 0);
    chk("R11 ack dropped", ackCycleReq, 0);
    chk("R11 tsc cleared", tscValue, 0);
    rst = 1'b0;
    tick();
    // R11: reset from stopped
    enterStop(0, 0, 0);
    rst = 1'b1;
    tick();
    chk("R11 reset from stopped", stateCode, 0);
    chk("R11 clock on", coreClkEn, 1);
    rst = 1'b0;
    stopReqN = 1'b1;
    tick();
    chk("R5 tsc restart", tscValue, expTsc);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule